// File: doc/BRIEF.md
# Next-Line Prefetch Generator

This block sits beside a second-level cache and watches the demand requests arriving there. For every demand trigger it forms a speculative read of the following cache line, at the trigger address plus one line size, applied to both the physical and the virtual address. It then offers that read to an external request queue, which it sees only through a full flag and a push strobe.

A candidate is discarded if the next line falls on another page, judged from the physical address. It is also discarded if the trigger is marked uncacheable. If the queue is full when the candidate is ready, the candidate is dropped rather than held. The trigger side has no ready signal, so demand traffic is never stalled.

Two saturating counters record how many candidates passed the page and cacheability checks, and how many of those were dropped because the queue was full. A pushed request carries a read opcode, a tag that marks it as a second-level prefetch, no links to miss-tracking entries, and the trigger's instruction-fetch flag.

Top module: `npf_prefetch_gen`

## Requirements
- R1: A trigger sampled at clock edge k yields, during the cycle after edge k, `pf_paddr` = trigger physical address + `LINE_BYTES` and `pf_vaddr` = trigger virtual address + `LINE_BYTES`, both modulo 2^`AW`.
- R2: No push occurs when the physical address bits above the page offset (bits `AW-1` down to log2(`PAGE_BYTES`)) of the next-line address differ from those of the trigger. This includes wrap-around past the top of the address space. The virtual address plays no part in this test.
- R3: No push occurs and no counter moves for a trigger with `trig_uncached` = 1.
- R4: `pf_attempt_cnt` rises by one, at edge k+1, for each trigger of edge k that passes the page and cacheability checks, whether or not it is pushed. It does not rise for any other trigger.
- R5: When a candidate is ready and `q_full` = 1 in that cycle, `pf_push` stays 0 and `pf_drop_cnt` rises by one at the next edge. `pf_push` is never 1 while `q_full` = 1, and the block has no way to stall the trigger.
- R6: While `pf_push` = 1, `pf_kind` = 2'b00 (plain read), `pf_src_tag` = 3'b100 (second-level prefetch), `pf_l1_link` = 0, `pf_l2_link` = 0, and `pf_ifetch` equals the trigger's `trig_ifetch`.
- R7: Both counters hold at all ones (2^`CNT_W`-1) once reached, and never wrap to zero.
- R8: While `rst_n` is low and at the first cycle after it, `pf_push` = 0 and both counters read zero.
- R9: Triggers on consecutive cycles are each handled independently, one candidate per cycle with no loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Demand trigger present this cycle |
| trig_paddr | input | AW | Trigger physical address |
| trig_vaddr | input | AW | Trigger virtual address |
| trig_uncached | input | 1 | Trigger access is uncacheable |
| trig_ifetch | input | 1 | Trigger is an instruction fetch |
| q_full | input | 1 | External request queue cannot accept |
| pf_push | output | 1 | Push the prefetch into the queue this cycle |
| pf_paddr | output | AW | Prefetch physical address |
| pf_vaddr | output | AW | Prefetch virtual address |
| pf_ifetch | output | 1 | Copied instruction-fetch flag |
| pf_kind | output | 2 | Request opcode, 2'b00 = read |
| pf_src_tag | output | 3 | Origin tag, 3'b100 = second-level prefetch |
| pf_l1_link | output | 1 | First-level miss-entry link valid, always 0 |
| pf_l2_link | output | 1 | Second-level miss-entry link valid, always 0 |
| pf_attempt_cnt | output | CNT_W | Saturating count of checked candidates |
| pf_drop_cnt | output | CNT_W | Saturating count of candidates lost to a full queue |

## Verification
A trigger sampled at one rising edge produces its push decision and addresses as combinational outputs in the following cycle. Those outputs depend on `q_full` within that same cycle. The counters then move at the next edge. The bench drives each cycle's inputs just after a falling edge and samples one nanosecond later. Its behavioural model holds the previous edge's trigger and compares the push, the address fields and the counters against it in every cycle. This puts each check exactly one edge after the trigger for the push, and two edges after it for the counters.

// File: rtl/npf_pkg.sv
package npf_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_OWN   = 2'b10,
    KIND_UPG   = 2'b11
  } npf_kind_e;

  typedef enum logic [2:0] {
    SRC_DEMAND = 3'b000,
    SRC_L1_PF  = 3'b010,
    SRC_L2_PF  = 3'b100
  } npf_src_e;

endpackage

// File: rtl/npf_stage.sv
module npf_stage #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] in_paddr,
  input  logic [AW-1:0] in_vaddr,
  input  logic          in_uncached,
  input  logic          in_ifetch,
  output logic          s_valid,
  output logic [AW-1:0] s_paddr,
  output logic [AW-1:0] s_vaddr,
  output logic          s_uncached,
  output logic          s_ifetch
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_valid    <= 1'b0;
      s_paddr    <= '0;
      s_vaddr    <= '0;
      s_uncached <= 1'b0;
      s_ifetch   <= 1'b0;
    end else begin
      s_valid    <= in_valid;
      s_paddr    <= in_paddr;
      s_vaddr    <= in_vaddr;
      s_uncached <= in_uncached;
      s_ifetch   <= in_ifetch;
    end
  end

endmodule

// File: rtl/npf_addr_calc.sv
module npf_addr_calc #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int PAGE_BYTES = 4096
) (
  input  logic [AW-1:0] cur_paddr,
  input  logic [AW-1:0] cur_vaddr,
  output logic [AW-1:0] nxt_paddr,
  output logic [AW-1:0] nxt_vaddr,
  output logic          same_page
);

  localparam int PG_W = $clog2(PAGE_BYTES);

  function automatic logic [AW-1:0] f_next_line(input logic [AW-1:0] a);
    return a + AW'(LINE_BYTES);
  endfunction

  function automatic logic [AW-PG_W-1:0] f_page_num(input logic [AW-1:0] a);
    return a[AW-1:PG_W];
  endfunction

  initial begin
    if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0)
      $error("line and page sizes must be powers of two");
    if (LINE_BYTES > PAGE_BYTES || PG_W >= AW)
      $error("page must hold a line and fit the address");
  end

  always_comb begin
    nxt_paddr = f_next_line(cur_paddr);
    nxt_vaddr = f_next_line(cur_vaddr);
    same_page = (f_page_num(nxt_paddr) == f_page_num(cur_paddr));
  end

endmodule

// File: rtl/npf_sat_counter.sv
module npf_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  logic at_max;
  assign at_max = &count;

  always_ff @(posedge clk) begin
    if (!rst_n)                count <= '0;
    else if (inc && !at_max)   count <= count + CNT_W'(1);
  end

  // R4 / R5: a counted event moves the count by exactly one
  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && (count != {CNT_W{1'b1}})) |=> (count == $past(count) + CNT_W'(1)));

  // R7: once full the count stays full
  p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (count == {CNT_W{1'b1}}) |=> (count == {CNT_W{1'b1}}));

  // R4 / R5: no event, no movement
  p_idle_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count));

endmodule

// File: rtl/npf_prefetch_gen.sv
module npf_prefetch_gen
  import npf_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int PAGE_BYTES = 4096,
  parameter int CNT_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_valid,
  input  logic [AW-1:0]    trig_paddr,
  input  logic [AW-1:0]    trig_vaddr,
  input  logic             trig_uncached,
  input  logic             trig_ifetch,
  input  logic             q_full,
  output logic             pf_push,
  output logic [AW-1:0]    pf_paddr,
  output logic [AW-1:0]    pf_vaddr,
  output logic             pf_ifetch,
  output logic [1:0]       pf_kind,
  output logic [2:0]       pf_src_tag,
  output logic             pf_l1_link,
  output logic             pf_l2_link,
  output logic [CNT_W-1:0] pf_attempt_cnt,
  output logic [CNT_W-1:0] pf_drop_cnt
);

  localparam int PG_W  = $clog2(PAGE_BYTES);
  localparam int N_CNT = 2;

  logic          s_valid, s_uncached, s_ifetch;
  logic [AW-1:0] s_paddr, s_vaddr;
  logic [AW-1:0] nxt_paddr, nxt_vaddr;
  logic          same_page;

  // named events for the assertions
  logic ev_eligible;
  logic ev_drop;
  logic [N_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_val [N_CNT];

  npf_stage #(.AW(AW)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (trig_valid),
    .in_paddr   (trig_paddr),
    .in_vaddr   (trig_vaddr),
    .in_uncached(trig_uncached),
    .in_ifetch  (trig_ifetch),
    .s_valid    (s_valid),
    .s_paddr    (s_paddr),
    .s_vaddr    (s_vaddr),
    .s_uncached (s_uncached),
    .s_ifetch   (s_ifetch)
  );

  npf_addr_calc #(
    .AW(AW), .LINE_BYTES(LINE_BYTES), .PAGE_BYTES(PAGE_BYTES)
  ) u_calc (
    .cur_paddr(s_paddr),
    .cur_vaddr(s_vaddr),
    .nxt_paddr(nxt_paddr),
    .nxt_vaddr(nxt_vaddr),
    .same_page(same_page)
  );

  assign ev_eligible = s_valid && !s_uncached && same_page;
  assign ev_drop     = ev_eligible && q_full;
  assign pf_push     = ev_eligible && !q_full;

  assign pf_paddr   = nxt_paddr;
  assign pf_vaddr   = nxt_vaddr;
  assign pf_ifetch  = s_ifetch;
  assign pf_kind    = KIND_READ;
  assign pf_src_tag = SRC_L2_PF;
  assign pf_l1_link = 1'b0;
  assign pf_l2_link = 1'b0;

  assign cnt_inc[0] = ev_eligible;
  assign cnt_inc[1] = ev_drop;

  for (genvar gi = 0; gi < N_CNT; gi++) begin : g_cnt
    npf_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (cnt_inc[gi]),
      .count(cnt_val[gi])
    );
  end

  assign pf_attempt_cnt = cnt_val[0];
  assign pf_drop_cnt    = cnt_val[1];

  // R5: never push into a full queue
  p_no_push_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !pf_push);

  // R3: uncacheable triggers produce nothing
  p_uncached_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_uncached) |-> (!pf_push && !ev_drop));

  // R2: a pushed address shares the trigger's page
  p_same_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pf_push |-> ((pf_paddr >> PG_W) == (s_paddr >> PG_W)));

  // R1: pushed address lies exactly one line above the trigger
  p_line_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pf_push |-> ((pf_paddr - s_paddr) == AW'(LINE_BYTES)
                 && (pf_vaddr - s_vaddr) == AW'(LINE_BYTES)));

  // R5: drops never outnumber attempts
  p_drop_le_attempt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pf_drop_cnt <= pf_attempt_cnt);

  // R6: pushed request fields
  p_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pf_push |-> (pf_kind == 2'b00 && pf_src_tag == 3'b100 && !pf_l1_link && !pf_l2_link));

endmodule

// File: tb/tb_npf_prefetch_gen.sv
module tb_npf_prefetch_gen;

  localparam int AW    = 32;
  localparam int LINE  = 64;
  localparam int PAGE  = 4096;
  localparam int CW    = 6;
  localparam int MAXC  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          trig_valid, trig_uncached, trig_ifetch, q_full;
  logic [AW-1:0] trig_paddr, trig_vaddr;
  logic          pf_push, pf_ifetch, pf_l1_link, pf_l2_link;
  logic [AW-1:0] pf_paddr, pf_vaddr;
  logic [1:0]    pf_kind;
  logic [2:0]    pf_src_tag;
  logic [CW-1:0] pf_attempt_cnt, pf_drop_cnt;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit        m_v, m_unc, m_if;
  longint    m_pa, m_va;
  int        m_att, m_drop;

  always #4 clk = ~clk;

  npf_prefetch_gen #(.AW(AW), .LINE_BYTES(LINE), .PAGE_BYTES(PAGE), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_paddr(trig_paddr),
    .trig_vaddr(trig_vaddr), .trig_uncached(trig_uncached), .trig_ifetch(trig_ifetch),
    .q_full(q_full), .pf_push(pf_push), .pf_paddr(pf_paddr), .pf_vaddr(pf_vaddr),
    .pf_ifetch(pf_ifetch), .pf_kind(pf_kind), .pf_src_tag(pf_src_tag),
    .pf_l1_link(pf_l1_link), .pf_l2_link(pf_l2_link),
    .pf_attempt_cnt(pf_attempt_cnt), .pf_drop_cnt(pf_drop_cnt)
  );

  function automatic longint wrap_add(longint a);
    return (a + LINE) % (64'd1 << AW);
  endfunction

  function automatic bit page_ok(longint a);
    return (a / PAGE) == (wrap_add(a) / PAGE);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_v = 0; m_att = 0; m_drop = 0;
    end else begin
      if (m_v && !m_unc && page_ok(m_pa)) begin
        if (m_att < MAXC) m_att++;
        if (q_full && m_drop < MAXC) m_drop++;
      end
      m_v   = trig_valid;
      m_pa  = longint'(trig_paddr);
      m_va  = longint'(trig_vaddr);
      m_unc = trig_uncached;
      m_if  = trig_ifetch;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit    exp_push;
    string why;
    exp_push = m_v && !m_unc && page_ok(m_pa) && !q_full;
    if (!m_v)                why = "R9";
    else if (m_unc)          why = "R3";
    else if (!page_ok(m_pa)) why = "R2";
    else if (q_full)         why = "R5";
    else                     why = "R1";
    chk(pf_push == exp_push, why, "push", pf_push, exp_push);
    if (exp_push) begin
      chk(longint'(pf_paddr) == wrap_add(m_pa), "R1", "paddr", pf_paddr, wrap_add(m_pa));
      chk(longint'(pf_vaddr) == wrap_add(m_va), "R1", "vaddr", pf_vaddr, wrap_add(m_va));
      chk(pf_ifetch == m_if, "R6", "ifetch", pf_ifetch, m_if);
      chk(pf_kind == 2'b00 && pf_src_tag == 3'b100 && !pf_l1_link && !pf_l2_link,
          "R6", "fields", {pf_kind, pf_src_tag, pf_l1_link, pf_l2_link}, 7'b0010000);
    end
    chk(int'(pf_attempt_cnt) == m_att, (m_att == MAXC) ? "R7" : "R4", "attempt",
        pf_attempt_cnt, m_att);
    chk(int'(pf_drop_cnt) == m_drop, (m_drop == MAXC) ? "R7" : "R5", "drop",
        pf_drop_cnt, m_drop);
  endtask

  task automatic step(bit v, longint pa, longint va, bit unc, bit ifc, bit full);
    @(negedge clk);
    trig_valid = v; trig_paddr = pa[AW-1:0]; trig_vaddr = va[AW-1:0];
    trig_uncached = unc; trig_ifetch = ifc; q_full = full;
    #1;
    compare();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; trig_valid = 1; trig_paddr = 32'h1000; trig_vaddr = 32'h1000;
    trig_uncached = 0; trig_ifetch = 0; q_full = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R8: reset state
    chk(pf_push == 0, "R8", "push in reset", pf_push, 0);
    chk(pf_attempt_cnt == 0 && pf_drop_cnt == 0, "R8", "counters in reset",
        {pf_attempt_cnt, pf_drop_cnt}, 0);
    trig_valid = 0;
    @(negedge clk); rst_n = 1;
    #1;
    chk(pf_push == 0, "R8", "push after reset", pf_push, 0);
    // R1 basic, R6 ifetch copy
    step(1, 64'h0000_2000, 64'h7000_2040, 0, 1, 0);
    step(1, 64'h0000_2F80, 64'h7000_3FC0, 0, 0, 0);  // next stays in page; va crosses (R2: va ignored)
    step(1, 64'h0000_2FC0, 64'h7000_2000, 0, 0, 0);  // R2 cross page
    step(1, 64'h0000_3010, 64'h0000_3010, 1, 0, 0);  // R3 uncached
    step(1, 64'h0000_4000, 64'h0000_4000, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1);                           // R5 candidate meets full queue
    step(1, 64'hFFFF_FFC0, 64'hFFFF_FFC0, 0, 0, 0);  // R2 wrap at top
    step(1, 64'h0001_0000, 64'h0001_0000, 0, 0, 0);  // R9 back to back
    step(1, 64'h0001_0040, 64'h0001_0040, 0, 1, 0);
    step(1, 64'h0001_0080, 64'h0001_0080, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    // random traffic; drives counters into saturation (R7)
    for (int i = 0; i < 3000; i++) begin
      longint pa;
      pa = {$urandom, $urandom} & 64'hFFFF_FFFF;
      if ($urandom_range(0, 3) == 0) pa = (pa & 64'hFFFF_F000) | 64'hFC0 | (pa & 64'h3F);
      step($urandom_range(0, 3) != 0, pa, longint'($urandom), $urandom_range(0, 7) == 0,
           $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0);
    end
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule